// File: doc/BRIEF.md
# Program Counter Sequencer with Three-Level Return Stack

This block holds the 12-bit program counter of a small 4-bit processor core and decides, every clock, where the next instruction fetch comes from. An instruction decoder outside the block presents a command code together with the instruction's second byte, a 4-bit immediate field and the current value of the selected index register. The sequencer then steps the counter, calls or returns through a return stack that is three entries deep, jumps inside a page through a register-pair value, or runs a counted loop branch.

The loop branch adds one to the index register and hands the new value back for write-back. It then either branches within the page or falls through. A return also gives the accumulator a constant taken from the instruction, because the core has no plain return. Page-relative targets use the page of the counter after it has moved past the instruction. An instruction in the last bytes of a 256-byte page therefore lands in the following page.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes 0, `acc_ld_o` and `idx_wr_o` become 0, and all three stack entries are cleared to 0.
- R2: Command code 1 (step) sets `pc_o` to `pc_o + 1` at the next edge, wrapping from 0xFFF to 0x000.
- R3: Command code 2 (call) loads `pc_o` with `{imm_i, operand_i}` and saves `pc_o + 2` on the stack as the return address.
- R4: Command code 3 (return) loads `pc_o` with the most recently saved address and pulses `acc_ld_o` high for exactly one cycle, with `acc_val_o` equal to `imm_i`.
- R5: Up to three nested calls return in last-in, first-out order.
- R6: A fourth call made without a return discards the oldest saved address. A return made when every saved address has been used again yields the oldest surviving entry, which is 0 if nothing was pushed since reset.
- R7: Command code 4 (indirect jump) loads `pc_o` with `{upper 4 bits of pc_o + 1, operand_i}`, so a jump located at offset 0xFF of a page lands in the next page.
- R8: Command code 5 (loop branch) outputs `idx_val_o = idx_i + 1`, wrapping from 15 to 0, with a one-cycle `idx_wr_o` pulse. When the new value is non-zero, `pc_o` becomes `{upper 4 bits of pc_o + 2, operand_i}`; when it is zero, `pc_o` becomes `pc_o + 2`.
- R9: A loop branch located at page offset 0xFE or 0xFF branches into the next page, because its page is taken from `pc_o + 2`.
- R10: Command code 0, and the unused codes 6 and 7, leave `pc_o` and the stack unchanged and keep both strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code: 0 idle, 1 step, 2 call, 3 return, 4 indirect jump, 5 loop branch |
| operand_i | input | 8 | Second instruction byte, or the register-pair value for an indirect jump |
| imm_i | input | 4 | Immediate field: upper call-target nibble, or the return constant |
| idx_i | input | 4 | Current value of the selected index register |
| pc_o | output | 12 | Program counter |
| idx_val_o | output | 4 | Incremented index-register value |
| idx_wr_o | output | 1 | One-cycle strobe to write `idx_val_o` back |
| acc_val_o | output | 4 | Constant delivered to the accumulator |
| acc_ld_o | output | 1 | One-cycle strobe to load `acc_val_o` into the accumulator |

## Verification
The hardest state to reach is a stack that has overflowed and then been drained past its depth. At that point the stack must still yield the oldest surviving address again, rather than zero or a stale newer entry. The stimulus makes four nested calls to distinct, easily recognised targets, then issues five returns, and so walks through the discard and the repeat. Page-boundary behaviour is reached by calling directly to offsets 0xFE and 0xFF and placing loop branches and indirect jumps there.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PC_W    = 12;
    localparam int OFS_W   = 8;
    localparam int PAGE_W  = PC_W - OFS_W;
    localparam int IMM_W   = 4;
    localparam int IDX_W   = 4;
    localparam int DEPTH   = 3;
    localparam int CMD_W   = 3;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [IMM_W-1:0] imm_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [CMD_W-1:0] {
        SQ_IDLE = 3'd0,
        SQ_STEP = 3'd1,
        SQ_CALL = 3'd2,
        SQ_RET  = 3'd3,
        SQ_JIN  = 3'd4,
        SQ_LOOP = 3'd5
    } sq_cmd_e;

    typedef struct packed {
        pc_t  nxt_pc;
        logic push;
        logic pop;
        pc_t  push_pc;
        logic acc_ld;
        imm_t acc_val;
        logic idx_wr;
        idx_t idx_val;
    } sq_ctrl_t;

    function automatic pc_t page_jump(input pc_t base, input ofs_t ofs);
        return {base[PC_W-1:OFS_W], ofs};
    endfunction

endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack
    import pcseq_pkg::*;
#(
    parameter int LEVELS = DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  pc_t  push_pc,
    output pc_t  top_pc
);

    pc_t ent [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)       ent[g] <= '0;
                else if (push) ent[g] <= push_pc;
                else if (pop)  ent[g] <= ent[g+1];
            end
        end else if (g == LEVELS-1) begin : g_last
            // bottom keeps its value on pop so a drained stack repeats it
            always_ff @(posedge clk) begin
                if (rst)       ent[g] <= '0;
                else if (push) ent[g] <= ent[g-1];
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)       ent[g] <= '0;
                else if (push) ent[g] <= ent[g-1];
                else if (pop)  ent[g] <= ent[g+1];
            end
        end
    end

    assign top_pc = ent[0];

    // R3
    push_top_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> top_pc == $past(push_pc));

    // R5
    pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> top_pc == $past(ent[1]));

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  pc_t              pc,
    input  pc_t              stack_top,
    input  ofs_t             operand,
    input  imm_t             imm,
    input  idx_t             idx,
    output sq_ctrl_t         ctrl
);

    pc_t  pc_one;
    pc_t  pc_two;
    idx_t idx_inc;
    logic idx_zero;

    assign pc_one   = pc + PC_W'(1);
    assign pc_two   = pc + PC_W'(2);
    assign idx_inc  = idx + IDX_W'(1);
    assign idx_zero = (idx_inc == '0);

    always_comb begin
        ctrl         = '0;
        ctrl.nxt_pc  = pc;
        ctrl.acc_val = imm;
        ctrl.idx_val = idx_inc;
        ctrl.push_pc = pc_two;
        case (sq_cmd_e'(cmd))
            SQ_STEP: ctrl.nxt_pc = pc_one;
            SQ_CALL: begin
                ctrl.nxt_pc = {imm, operand};
                ctrl.push   = 1'b1;
            end
            SQ_RET: begin
                ctrl.nxt_pc = stack_top;
                ctrl.pop    = 1'b1;
                ctrl.acc_ld = 1'b1;
            end
            SQ_JIN:  ctrl.nxt_pc = page_jump(pc_one, operand);
            SQ_LOOP: begin
                ctrl.idx_wr = 1'b1;
                ctrl.nxt_pc = idx_zero ? pc_two : page_jump(pc_two, operand);
            end
            default: ctrl.nxt_pc = pc;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cmd_i,
    input  logic [7:0]  operand_i,
    input  logic [3:0]  imm_i,
    input  logic [3:0]  idx_i,
    output logic [11:0] pc_o,
    output logic [3:0]  idx_val_o,
    output logic        idx_wr_o,
    output logic [3:0]  acc_val_o,
    output logic        acc_ld_o
);

    pc_t      pc_q;
    pc_t      top_pc;
    sq_ctrl_t ctrl;

    pcseq_next u_next (
        .cmd       (cmd_i),
        .pc        (pc_q),
        .stack_top (top_pc),
        .operand   (operand_i),
        .imm       (imm_i),
        .idx       (idx_i),
        .ctrl      (ctrl)
    );

    pcseq_stack #(.LEVELS(DEPTH)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push    (ctrl.push),
        .pop     (ctrl.pop),
        .push_pc (ctrl.push_pc),
        .top_pc  (top_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            acc_ld_o  <= 1'b0;
            acc_val_o <= '0;
            idx_wr_o  <= 1'b0;
            idx_val_o <= '0;
        end else begin
            pc_q      <= ctrl.nxt_pc;
            acc_ld_o  <= ctrl.acc_ld;
            acc_val_o <= ctrl.acc_val;
            idx_wr_o  <= ctrl.idx_wr;
            idx_val_o <= ctrl.idx_val;
        end
    end

    assign pc_o = pc_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && !acc_ld_o && !idx_wr_o));

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd1) |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));

    // R4
    ret_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd3) |=> (acc_ld_o && acc_val_o == $past(imm_i)));

    // R7
    jin_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd4) |=> pc_o[OFS_W-1:0] == $past(operand_i));

    // R8
    loop_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd5) |=> (idx_wr_o && idx_val_o == IDX_W'($past(idx_i) + IDX_W'(1))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd0) |=> ($stable(pc_o) && !acc_ld_o && !idx_wr_o));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_ld_o, idx_wr_o}));

endmodule

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;

    typedef struct {
        logic [11:0] pc;
        logic        acc_ld;
        logic [3:0]  acc_val;
        logic        idx_wr;
        logic [3:0]  idx_val;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_i = 3'd0;
    logic [7:0]  operand_i = 8'd0;
    logic [3:0]  imm_i = 4'd0;
    logic [3:0]  idx_i = 4'd0;
    logic [11:0] pc_o;
    logic [3:0]  idx_val_o;
    logic        idx_wr_o;
    logic [3:0]  acc_val_o;
    logic        acc_ld_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    exp_t        q[$];
    logic [11:0] m_pc;
    logic [11:0] m_stk [3];

    always #4 clk = ~clk;

    pc_sequencer dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd_i),
        .operand_i (operand_i),
        .imm_i     (imm_i),
        .idx_i     (idx_i),
        .pc_o      (pc_o),
        .idx_val_o (idx_val_o),
        .idx_wr_o  (idx_wr_o),
        .acc_val_o (acc_val_o),
        .acc_ld_o  (acc_ld_o)
    );

    task automatic drive(input logic [2:0] c, input logic [7:0] op,
                         input logic [3:0] im, input logic [3:0] ix, input string tag);
        exp_t        e;
        logic [11:0] p1, p2;
        logic [3:0]  ninc;
        @(negedge clk);
        cmd_i = c; operand_i = op; imm_i = im; idx_i = ix;
        p1 = m_pc + 12'd1;
        p2 = m_pc + 12'd2;
        ninc = ix + 4'd1;
        e.tag = tag; e.acc_ld = 1'b0; e.idx_wr = 1'b0;
        e.acc_val = im; e.idx_val = ninc;
        case (c)
            3'd1: m_pc = p1;
            3'd2: begin
                m_stk[2] = m_stk[1]; m_stk[1] = m_stk[0]; m_stk[0] = p2;
                m_pc = {im, op};
            end
            3'd3: begin
                m_pc = m_stk[0];
                m_stk[0] = m_stk[1]; m_stk[1] = m_stk[2];
                e.acc_ld = 1'b1;
            end
            3'd4: m_pc = {p1[11:8], op};
            3'd5: begin
                e.idx_wr = 1'b1;
                m_pc = (ninc == 4'd0) ? p2 : {p2[11:8], op};
            end
            default: ;
        endcase
        e.pc = m_pc;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (pc_o !== e.pc || acc_ld_o !== e.acc_ld || idx_wr_o !== e.idx_wr ||
                (e.acc_ld && acc_val_o !== e.acc_val) ||
                (e.idx_wr && idx_val_o !== e.idx_val)) begin
                n_fail++;
                $display("FAIL %s: pc=%h ld=%b acc=%h wr=%b idx=%h expected pc=%h ld=%b acc=%h wr=%b idx=%h",
                         e.tag, pc_o, acc_ld_o, acc_val_o, idx_wr_o, idx_val_o,
                         e.pc, e.acc_ld, e.acc_val, e.idx_wr, e.idx_val);
            end
        end
    end

    initial begin
        m_pc = 12'd0;
        for (int i = 0; i < 3; i++) m_stk[i] = 12'd0;
        cmd_i = 3'd2; operand_i = 8'h55; imm_i = 4'h7;
        repeat (3) @(posedge clk);
        #2;
        n_run++;
        if (pc_o !== 12'd0 || acc_ld_o !== 1'b0 || idx_wr_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: pc=%h ld=%b wr=%b expected pc=000 ld=0 wr=0",
                     pc_o, acc_ld_o, idx_wr_o);
        end
        @(negedge clk);
        rst = 1'b0;
        cmd_i = 3'd0;

        drive(3'd3, 8'h00, 4'h9, 4'h0, "R6 return on empty stack after reset (R1 cleared)");
        drive(3'd1, 8'h00, 4'h0, 4'h0, "R2 step");
        drive(3'd1, 8'h00, 4'h0, 4'h0, "R2 step");
        drive(3'd0, 8'hAA, 4'hB, 4'h0, "R10 idle hold");
        drive(3'd7, 8'h12, 4'h3, 4'h0, "R10 unused code");
        drive(3'd2, 8'hFF, 4'hF, 4'h0, "R3 call to 0xFFF");
        drive(3'd1, 8'h00, 4'h0, 4'h0, "R2 step wraps to 0");
        drive(3'd3, 8'h00, 4'h4, 4'h0, "R4 return with constant");
        drive(3'd2, 8'h10, 4'h1, 4'h0, "R3 call A");
        drive(3'd2, 8'h20, 4'h2, 4'h0, "R3 call B");
        drive(3'd2, 8'h30, 4'h3, 4'h0, "R5 call C");
        drive(3'd3, 8'h00, 4'hC, 4'h0, "R5 return C");
        drive(3'd3, 8'h00, 4'hB, 4'h0, "R5 return B");
        drive(3'd3, 8'h00, 4'hA, 4'h0, "R5 return A");
        drive(3'd2, 8'h11, 4'h1, 4'h0, "R6 call 1");
        drive(3'd2, 8'h22, 4'h2, 4'h0, "R6 call 2");
        drive(3'd2, 8'h33, 4'h3, 4'h0, "R6 call 3");
        drive(3'd2, 8'h44, 4'h4, 4'h0, "R6 call 4 overwrites oldest");
        for (int i = 0; i < 5; i++)
            drive(3'd3, 8'h00, 4'(i), 4'h0, "R6 drain past depth");
        drive(3'd2, 8'h40, 4'h5, 4'h0, "R3 call to 0x540");
        drive(3'd4, 8'h9C, 4'h0, 4'h0, "R7 indirect jump mid page");
        drive(3'd2, 8'hFF, 4'h2, 4'h0, "R3 call to 0x2FF");
        drive(3'd4, 8'h07, 4'h0, 4'h0, "R7 indirect jump at 0xFF enters next page");
        drive(3'd5, 8'h3C, 4'h0, 4'h6, "R8 loop non-zero branches");
        drive(3'd5, 8'h3C, 4'h0, 4'hF, "R8 loop wraps to zero falls through");
        drive(3'd2, 8'hFE, 4'h6, 4'h0, "R3 call to 0x6FE");
        drive(3'd5, 8'h21, 4'h0, 4'h2, "R9 loop at 0xFE branches into next page");
        drive(3'd2, 8'hFF, 4'h8, 4'h0, "R3 call to 0x8FF");
        drive(3'd5, 8'h05, 4'h0, 4'h9, "R9 loop at 0xFF branches into next page");
        drive(3'd5, 8'h05, 4'h0, 4'hF, "R8 loop zero result");
        drive(3'd0, 8'h00, 4'h0, 4'h0, "R10 idle after loop");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule